// File: doc/BRIEF.md
# Keypad Combination Lock

This block is a clocked Moore state machine that watches a two-key keypad and recognises one fixed three-press code: key B, then key A, then key B. Each accepted press moves the machine one step, and a 4-bit press count that depends only on the current state tells a display how far the current attempt has got. When the full code has been entered, a one-cycle unlock pulse is raised.

A wrong press does not end the attempt on the spot. The machine moves to a separate reject path that keeps counting presses, and it goes back to idle only once three presses have been made. The display therefore never shows which press was wrong. Presses are given as a key-present flag together with two key-identity lines, all already synchronous to the clock. Each press is one cycle long. The block accepts input on every cycle and never applies back-pressure, so it has no ready signal.

Top module: `keypad_lock`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, with `key_count` = 0 and `unlock` = 0. This holds even when reset arrives in the middle of an attempt.
- R2: The input word {key_k, key_a, key_b} is read as follows: 3'b110 is a press of key A, 3'b101 is a press of key B, and every other value is treated as no press.
- R3: The presses B, A, B in that order reach the open state one clock after the third press. In that state `unlock` = 1 and `key_count` = 3.
- R4: The open state lasts exactly one cycle whatever the input, and the machine then returns to idle (`key_count` = 0, `unlock` = 0). A press made during the open cycle is ignored and does not start a new attempt.
- R5: `key_count` is 0 in idle, 1 after one press, 2 after two presses and 3 only in the open state, with bits above bit 1 always zero. The first and second presses of an attempt each raise the count by one, on both the good path and the reject path.
- R6: If the first press is A, the attempt moves to the reject path. The next two presses, of either key, give counts 2 and then 0, and `unlock` stays 0.
- R7: If the presses are B then B, the count is 2 on the reject path. The next press of either key returns the machine to idle with no unlock.
- R8: If the presses are B, A, A, the third press returns the machine to idle (count 0) with no unlock.
- R9: In every state except the open state, a cycle with no press leaves the state, and so the outputs, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_k | input | 1 | Key-present flag |
| key_a | input | 1 | Key A identity line |
| key_b | input | 1 | Key B identity line |
| unlock | output | 1 | One-cycle pulse when the code is complete |
| key_count | output | 4 | Number of presses in the current attempt |

## Verification
Both outputs are decoded from the state register alone. A press sampled at one rising edge therefore shows on `unlock` and `key_count` right after that edge, and not before. The bench changes inputs on falling edges, lets exactly one rising edge go by, and samples at the next falling edge. Each expected value then belongs to the single press just applied. The return from the open state to idle is due one edge later still, and it is checked on the following falling edge, both with a filler code and with a real press present.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 3'b000,
    ST_OK1  = 3'b001,
    ST_OK2  = 3'b010,
    ST_OPEN = 3'b011,
    ST_BAD1 = 3'b100,
    ST_BAD2 = 3'b101
  } lock_state_e;

  typedef enum logic [1:0] {
    KEY_NONE = 2'b00,
    KEY_A    = 2'b01,
    KEY_B    = 2'b10
  } key_e;

  // Position of each state along an attempt (number of presses taken).
  function automatic int unsigned state_depth(lock_state_e s);
    case (s)
      ST_OK1, ST_BAD1: return 1;
      ST_OK2, ST_BAD2: return 2;
      ST_OPEN:         return 3;
      default:         return 0;
    endcase
  endfunction

endpackage

// File: rtl/lock_key_decode.sv
module lock_key_decode
  import lock_pkg::*;
(
  input  logic key_k,
  input  logic key_a,
  input  logic key_b,
  output key_e key
);
  always_comb begin
    case ({key_k, key_a, key_b})
      3'b110:  key = KEY_A;
      3'b101:  key = KEY_B;
      default: key = KEY_NONE;  // idle or malformed word
    endcase
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_e cur,
  input  key_e        key,
  output lock_state_e nxt
);
  logic pressed;
  assign pressed = (key != KEY_NONE);

  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE: begin
        if (key == KEY_B)      nxt = ST_OK1;
        else if (key == KEY_A) nxt = ST_BAD1;
      end
      ST_OK1: begin
        if (key == KEY_A)      nxt = ST_OK2;
        else if (key == KEY_B) nxt = ST_BAD2;
      end
      ST_OK2: begin
        if (key == KEY_B)      nxt = ST_OPEN;
        else if (key == KEY_A) nxt = ST_IDLE;
      end
      ST_OPEN: nxt = ST_IDLE;
      ST_BAD1: if (pressed) nxt = ST_BAD2;
      ST_BAD2: if (pressed) nxt = ST_IDLE;
      default: nxt = ST_IDLE;  // unused codes recover
    endcase
  end
endmodule

// File: rtl/lock_out_decode.sv
module lock_out_decode
  import lock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  lock_state_e     cur,
  output logic            unlock,
  output logic [CNT_W-1:0] count
);
  localparam int DEPTH_W = 2;

  logic [DEPTH_W-1:0] depth;
  assign depth  = DEPTH_W'(state_depth(cur));
  assign unlock = (cur == ST_OPEN);

  generate
    if (CNT_W > DEPTH_W) begin : g_wide
      assign count = {{(CNT_W-DEPTH_W){1'b0}}, depth};
    end else begin : g_narrow
      assign count = depth[CNT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/keypad_lock.sv
module keypad_lock
  import lock_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_k,
  input  logic             key_a,
  input  logic             key_b,
  output logic             unlock,
  output logic [CNT_W-1:0] key_count
);
  key_e        key;
  lock_state_e cur_q, nxt;

  lock_key_decode u_dec (
    .key_k(key_k), .key_a(key_a), .key_b(key_b), .key(key)
  );

  lock_next_state u_ns (
    .cur(cur_q), .key(key), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) cur_q <= ST_IDLE;
    else     cur_q <= nxt;
  end

  lock_out_decode #(.CNT_W(CNT_W)) u_out (
    .cur(cur_q), .unlock(unlock), .count(key_count)
  );
endmodule

// File: rtl/keypad_lock_chk.sv
module keypad_lock_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             key_k,
  input logic             key_a,
  input logic             key_b,
  input logic             unlock,
  input logic [CNT_W-1:0] key_count
);
  logic pr_a, pr_b, pr_any;
  always_comb begin
    pr_a   = key_k && key_a && !key_b;
    pr_b   = key_k && key_b && !key_a;
    pr_any = pr_a || pr_b;
  end

  AST_OPEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    unlock |=> (!unlock && key_count == '0));  // R4

  AST_OPEN_AFTER_B: assert property (@(posedge clk) disable iff (rst)
    unlock |-> $past(pr_b));  // R3

  AST_HOLD_IDLE_INPUT: assert property (@(posedge clk) disable iff (rst)
    (!pr_any && !unlock) |=> ($stable(key_count) && !unlock));  // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pr_any && !unlock && key_count < CNT_W'(2)) |=>
      (key_count == $past(key_count) + CNT_W'(1)));  // R5

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (key_count <= CNT_W'(3)) && (unlock == (key_count == CNT_W'(3))));  // R5

  AST_THIRD_A_REJECT: assert property (@(posedge clk) disable iff (rst)
    (pr_a && key_count == CNT_W'(2)) |=> (key_count == '0 && !unlock));  // R8
endmodule

bind keypad_lock keypad_lock_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .key_k(key_k), .key_a(key_a), .key_b(key_b),
  .unlock(unlock), .key_count(key_count)
);

// File: tb/keypad_lock_tb_top.sv
`timescale 1ns/1ps
module keypad_lock_tb_top;
  localparam int CNT_W = 4;
  localparam logic [2:0] CODE_A = 3'b110;
  localparam logic [2:0] CODE_B = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] kin = 3'b000;
  logic unlock;
  logic [CNT_W-1:0] key_count;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keypad_lock #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .key_k(kin[2]), .key_a(kin[1]), .key_b(kin[0]),
    .unlock(unlock), .key_count(key_count)
  );

  task automatic chk(input string req, input int exp_cnt, input bit exp_unl);
    checks++;
    if (key_count !== CNT_W'(exp_cnt) || unlock !== exp_unl) begin
      errors++;
      $display("FAIL %s: count=%0d unlock=%0b expected count=%0d unlock=%0b",
               req, key_count, unlock, exp_cnt, exp_unl);
    end
  endtask

  // Called at a falling edge: apply code, pass one rising edge, land on next falling edge.
  task automatic step(input logic [2:0] code);
    kin = code;
    @(posedge clk);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(3'b000);
    step(3'b000);
    chk("R1", 0, 1'b0);
    rst = 1'b0;

    // Exhaustive sweep: every three-press A/B sequence with every filler code.
    for (int s = 0; s < 8; s++) begin
      for (int f = 0; f < 8; f++) begin
        if (f == 5 || f == 6) continue;
        for (int i = 0; i < 3; i++) begin
          string tag;
          bit good;
          step(s[i] ? CODE_B : CODE_A);
          good = (s == 5);  // B, A, B
          if (i < 2) begin
            chk("R5", i + 1, 1'b0);
            step(3'(f));
            chk((f == 0) ? "R9" : "R2", i + 1, 1'b0);
          end else begin
            if (good)            tag = "R3";
            else if (s[0] == 0)  tag = "R6";
            else if (s[1] == 1)  tag = "R7";
            else                 tag = "R8";
            chk(tag, good ? 3 : 0, good);
            step(3'(f));
            chk(good ? "R4" : "R9", 0, 1'b0);
          end
        end
      end
    end

    // Press during the open cycle is ignored.
    step(CODE_B); step(CODE_A); step(CODE_B);
    chk("R3", 3, 1'b1);
    step(CODE_B);
    chk("R4", 0, 1'b0);
    step(CODE_A);
    chk("R4", 1, 1'b0);   // A from idle: reject path, count 1
    step(CODE_B);
    chk("R6", 2, 1'b0);
    step(CODE_A);
    chk("R6", 0, 1'b0);

    // Long hold on the reject path with no press.
    step(CODE_B); step(CODE_B);
    for (int k = 0; k < 5; k++) begin
      step(3'b000);
      chk("R9", 2, 1'b0);
    end
    step(CODE_A);
    chk("R7", 0, 1'b0);

    // Reset in the middle of an attempt.
    step(CODE_B); step(CODE_A);
    chk("R5", 2, 1'b0);
    rst = 1'b1;
    step(CODE_B);
    chk("R1", 0, 1'b0);
    rst = 1'b0;
    step(CODE_B);
    chk("R1", 1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule